// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host-side master of a single-wire debug link. It moves whole bytes across one bidirectional line, bit by bit, most significant bit first. The host opens every bit cell with a falling edge. Every cell lasts sixteen target clock periods. One target period is a programmable number of host clocks. The line is presented as three pins: an output enable, an output value and the resolved input. An external pad and a pull-up join them into the shared wire.

A write cell is driven push-pull for the whole cell. A one is a short low pulse followed by a driven high, and a zero is a long low pulse followed by a driven high. In a read cell the host pulls the line low for a short time and then releases it. That release comes before the target can emit its speed-up pulse. The host then samples the level the target leaves on the line, ten target periods into the cell. Commands arrive on a valid/ready stream. Read bytes leave on a second valid/ready stream.

Back-pressure works as follows. A command is taken only on a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low while a byte is in flight and while a read result waits to be taken. A read result stays on `rsp_data` with `rsp_valid` high until `rsp_ready` is seen high at a clock edge. `done` is a plain single-cycle pulse that marks the end of every byte, read or write.

Top module: `dbg_link_host`

## Requirements
- R1: After reset the line is released (`line_oe`=0), `cmd_ready`=1, `rsp_valid`=0 and `done`=0.
- R2: A byte is eight cells of 16 target periods, sent or received MSB first. Each target period is `cfg_div` host clocks. Each cell begins with the line driven low (`line_oe`=1, `line_out`=0) in the first host clock after the command is accepted or after the previous cell ends.
- R3: In a write cell carrying a 1, the line is driven low for target periods 0 to 3 and driven high for periods 4 to 15. `line_oe` stays 1 for the whole write byte.
- R4: In a write cell carrying a 0, the line is driven low for target periods 0 to 12 and driven high for periods 13 to 15.
- R5: In a read cell, the host drives the line low for target periods 0 to 2 only. From period 3 to the end of the cell, `line_oe` is 0.
- R6: In a read cell, the line level is captured in the first host clock of target period 10. The eight captured levels form `rsp_data`, with the first cell in bit 7.
- R7: `done` is high for exactly the one host clock that begins 128×`cfg_div` host clocks after the accepting edge. From that clock on, the line is released and the engine is idle.
- R8: `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is high at an edge. `cmd_ready` is 0 while a byte is in flight or a result is pending, and a command offered then is not started.
- R9: `cfg_div` is captured when a command is accepted; a change during the byte has no effect on its timing, and a value of 0 is treated as 1.
- R10: A write byte produces no result: `rsp_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Host clocks per target period (0 acts as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_write | input | 1 | 1 = write byte, 0 = read byte |
| cmd_data | input | 8 | Byte to send on a write |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | 8 | Received byte, first bit in bit 7 |
| done | output | 1 | One-clock pulse at the end of each byte |
| line_oe | output | 1 | Line output enable |
| line_out | output | 1 | Line output value when enabled |
| line_in | input | 1 | Resolved line level |

## Verification
The host clock that follows an accepting edge is counted as cycle 0. For a divider d, cycle j lies in cell j/(16d) and target period (j mod 16d)/d. The bench compares `line_oe` and `line_out` against that formula at every falling clock edge of the byte. The read level is captured in cycle 10d of each cell, where the bench's target model is already driving the bit. `done`, `rsp_valid` and `rsp_data` are therefore checked in cycle 128d, and `done` is checked low again in the cycle after. Back-pressure is checked over several held cycles before `rsp_ready` rises, with a command offered the whole time. After the handshake edge, the next cycle must show the result gone and `cmd_ready` high.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CELL = 1'b1
  } eng_state_t;

  // Low-phase length of a write cell, in target periods, for a given bit value.
  function automatic int unsigned wr_low_len(input logic bit_val,
                                             input int unsigned one_low,
                                             input int unsigned zero_low);
    return bit_val ? one_low : zero_low;
  endfunction
endpackage

// File: rtl/dbg_link_prescale.sv
module dbg_link_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick,
  output logic             first
);
  logic [DIV_W-1:0] pcnt;

  assign tick  = (pcnt == div_q - DIV_W'(1));
  assign first = (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (!run || tick)  pcnt <= '0;
    else                    pcnt <= pcnt + DIV_W'(1);
  end
endmodule

// File: rtl/dbg_link_celltimer.sv
module dbg_link_celltimer #(
  parameter int CELL_T = 16,
  localparam int TW    = $clog2(CELL_T)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [TW-1:0] tcnt,
  output logic          cell_end
);
  localparam logic [TW-1:0] LAST = TW'(CELL_T - 1);

  assign cell_end = run && tick && (tcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tcnt <= '0;
    else if (!run)   tcnt <= '0;
    else if (tick)   tcnt <= (tcnt == LAST) ? '0 : tcnt + TW'(1);
  end
endmodule

// File: rtl/dbg_link_pad.sv
module dbg_link_pad #(
  parameter int TW       = 4,
  parameter int ONE_LOW  = 4,
  parameter int ZERO_LOW = 13,
  parameter int RD_LOW   = 3
) (
  input  logic          active,
  input  logic          mode_wr,
  input  logic          bit_val,
  input  logic [TW-1:0] tcnt,
  output logic          line_oe,
  output logic          line_out
);
  import dbg_link_pkg::*;

  logic [TW-1:0] low_len;

  always_comb begin
    low_len  = TW'(wr_low_len(bit_val, ONE_LOW, ZERO_LOW));
    line_oe  = 1'b0;
    line_out = 1'b0;
    if (active) begin
      if (mode_wr) begin
        line_oe  = 1'b1;
        line_out = (tcnt >= low_len);
      end else begin
        line_oe  = (tcnt < TW'(RD_LOW));
      end
    end
  end
endmodule

// File: rtl/dbg_link_host.sv
module dbg_link_host #(
  parameter int DIV_W     = 8,
  parameter int BITS      = 8,
  parameter int CELL_T    = 16,
  parameter int ONE_LOW   = 4,
  parameter int ZERO_LOW  = 13,
  parameter int RD_LOW    = 3,
  parameter int RD_SAMPLE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [BITS-1:0]  cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [BITS-1:0]  rsp_data,
  output logic             done,
  output logic             line_oe,
  output logic             line_out,
  input  logic             line_in
);
  import dbg_link_pkg::*;

  localparam int TW = $clog2(CELL_T);
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

  eng_state_t       state;
  logic             mode_wr;
  logic [BITS-1:0]  shreg;
  logic [BW-1:0]    bidx;
  logic [DIV_W-1:0] div_q;
  logic             busy, tick, first, cell_end, sample_en, accept, last_bit;
  logic [TW-1:0]    tcnt;

  assign busy      = (state == ST_CELL);
  assign cmd_ready = (state == ST_IDLE) && !rsp_valid;
  assign accept    = cmd_valid && cmd_ready;
  assign sample_en = busy && !mode_wr && first && tick_period_hit;
  assign last_bit  = (bidx == BW'(BITS - 1));

  logic tick_period_hit;
  assign tick_period_hit = (tcnt == TW'(RD_SAMPLE));

  dbg_link_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div_q (div_q),
    .tick  (tick),
    .first (first)
  );

  dbg_link_celltimer #(.CELL_T(CELL_T)) u_cell (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .tick     (tick),
    .tcnt     (tcnt),
    .cell_end (cell_end)
  );

  dbg_link_pad #(
    .TW       (TW),
    .ONE_LOW  (ONE_LOW),
    .ZERO_LOW (ZERO_LOW),
    .RD_LOW   (RD_LOW)
  ) u_pad (
    .active   (busy),
    .mode_wr  (mode_wr),
    .bit_val  (shreg[BITS-1]),
    .tcnt     (tcnt),
    .line_oe  (line_oe),
    .line_out (line_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_wr   <= 1'b0;
      shreg     <= '0;
      bidx      <= '0;
      div_q     <= DIV_W'(1);
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_CELL;
            mode_wr <= cmd_write;
            shreg   <= cmd_data;
            bidx    <= '0;
            div_q   <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
          end
        end
        default: begin
          if (sample_en) shreg <= {shreg[BITS-2:0], line_in};
          if (cell_end) begin
            if (mode_wr) shreg <= {shreg[BITS-2:0], 1'b0};
            if (last_bit) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              if (!mode_wr) begin
                rsp_valid <= 1'b1;
                rsp_data  <= shreg;
              end
            end else begin
              bidx <= bidx + BW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbg_link_host_chk.sv
module dbg_link_host_chk #(
  parameter int TW     = 4,
  parameter int BITS   = 8,
  parameter int RD_LOW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [BITS-1:0] rsp_data,
  input logic            done,
  input logic            line_oe,
  input logic            line_out,
  input logic            busy,
  input logic            mode_wr,
  input logic [TW-1:0]   tcnt
);
  // R1: an idle engine never drives the line
  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe);

  // R2: each cell opens with a driven low
  a_r2_cell_open_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tcnt == '0) |-> (line_oe && !line_out));

  // R3: a write byte keeps the driver enabled throughout
  a_r3_write_pushpull: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_wr) |-> line_oe);

  // R5: a read cell releases the line from the release period on
  a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_wr && tcnt >= TW'(RD_LOW)) |-> !line_oe);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a pending result holds until taken
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8: no command is taken while the line is in use
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !cmd_ready);

  // R10: only a read byte raises a result
  a_r10_write_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> !mode_wr);
endmodule

bind dbg_link_host dbg_link_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .done      (done),
  .line_oe   (line_oe),
  .line_out  (line_out),
  .busy      (busy),
  .mode_wr   (mode_wr),
  .tcnt      (tcnt)
);

// File: tb/dbg_link_host_test.sv
`timescale 1ns/1ps
module dbg_link_host_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, rsp_valid, done, line_oe, line_out, line_in;
  logic [7:0] rsp_data;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // Target model: releases to the pull-up unless the bit of the current read cell is 0.
  logic [7:0] tgt_byte = 8'hFF;
  logic [3:0] cell_cnt = 4'd0;
  logic       oe_q = 1'b0;
  logic       cnt_clr = 1'b0;
  logic       tgt_level;

  always @(posedge clk) begin
    oe_q <= line_oe;
    if (cnt_clr) cell_cnt <= 4'd0;
    else if (line_oe && !oe_q) cell_cnt <= cell_cnt + 4'd1;
  end

  always_comb begin
    if (cell_cnt == 4'd0 || cell_cnt > 4'd8) tgt_level = 1'b1;
    else tgt_level = tgt_byte[4'd8 - cell_cnt];
  end

  assign line_in = line_oe ? line_out : tgt_level;

  dbg_link_host uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .line_oe(line_oe), .line_out(line_out), .line_in(line_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // One byte: accept, per-cell line shape, end-of-byte results.
  task automatic run_byte(input bit wr, input logic [7:0] d, input int div_set,
                          input int div_eff, input int mid_div);
    int cyc = 16 * div_eff;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8", "ready before accept", cmd_ready, 1);
    cfg_div   = 8'(div_set);
    tgt_byte  = d;
    cnt_clr   = 1'b1;
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_data  = d;
    @(posedge clk);
    for (int b = 0; b < 8; b++) begin
      int bad_oe = 0, bad_out = 0;
      for (int k = 0; k < cyc; k++) begin
        int t;
        bit eoe, eout;
        @(negedge clk);
        if (b == 0 && k == 0) begin
          cmd_valid = 1'b0;
          cnt_clr   = 1'b0;
        end
        if (mid_div >= 0 && b == 1 && k == 3) cfg_div = 8'(mid_div);
        t = k / div_eff;
        if (wr) begin
          eoe  = 1'b1;
          eout = (t >= (d[7-b] ? 4 : 13));
        end else begin
          eoe  = (t < 3);
          eout = 1'b0;
        end
        if (line_oe !== eoe) bad_oe++;
        if (eoe && line_out !== eout) bad_out++;
        if (b == 0 && k == 2 && cmd_ready !== 1'b0) bad_oe++;
      end
      if (wr) begin
        check(bad_oe == 0, "R3", $sformatf("write oe cell %0d", b), bad_oe, 0);
        check(bad_out == 0, d[7-b] ? "R3" : "R4",
              $sformatf("write level cell %0d", b), bad_out, 0);
      end else begin
        check(bad_oe == 0, "R5", $sformatf("read release cell %0d", b), bad_oe, 0);
        check(bad_out == 0, "R2", $sformatf("read open low cell %0d", b), bad_out, 0);
      end
    end
    @(negedge clk);
    check(done == 1'b1, "R7", "done at end of byte", done, 1);
    check(line_oe == 1'b0, "R7", "line released", line_oe, 0);
    if (wr) begin
      check(rsp_valid == 1'b0, "R10", "no result for write", rsp_valid, 0);
      check(cmd_ready == 1'b1, "R7", "idle after write", cmd_ready, 1);
    end else begin
      check(rsp_valid == 1'b1, "R6", "result valid", rsp_valid, 1);
      check(rsp_data == d, "R6", "read byte MSB first", rsp_data, d);
    end
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle only", done, 0);
  endtask

  // Hold a read result under back-pressure while offering a command, then take it.
  task automatic drain_rsp(input logic [7:0] d);
    int bad = 0;
    cmd_valid = 1'b1;
    cmd_write = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (rsp_valid !== 1'b1 || rsp_data !== d || cmd_ready !== 1'b0 || line_oe !== 1'b0) bad++;
    end
    check(bad == 0, "R8", "result held, command refused", bad, 0);
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0, "R8", "result taken", rsp_valid, 0);
    check(cmd_ready == 1'b1, "R8", "ready after take", cmd_ready, 1);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(line_oe == 1'b0, "R1", "line released", line_oe, 0);
    check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    check(done == 1'b0, "R1", "done", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_reset();                          // R1
    run_byte(1'b1, 8'hA5, 1, 1, -1);       // R2 R3 R4 R7 R10
    run_byte(1'b1, 8'h3C, 3, 3, -1);       // R2 slower divider
    run_byte(1'b0, 8'h96, 1, 1, -1);       // R5 R6
    drain_rsp(8'h96);                      // R8
    run_byte(1'b0, 8'h5A, 2, 2, 7);        // R9 mid-byte change ignored
    drain_rsp(8'h5A);
    run_byte(1'b1, 8'h81, 0, 1, -1);       // R9 zero acts as one
    run_byte(1'b0, 8'hFF, 1, 1, -1);
    drain_rsp(8'hFF);
    run_byte(1'b0, 8'h00, 4, 4, -1);
    drain_rsp(8'h00);
    finish_run();
  end
endmodule